// File: doc/BRIEF.md
# Periodic Interrupt Timer with Vectored Request

This block produces an interrupt request at a fixed, programmable rate. A one-cycle reference enable runs through an optional fixed reference divider (divide by 128 in the fast-reference build), then through a prescaler that software can switch in. The prescaler divides by 512 when its select bit is set and passes the enable through when the bit is clear. A fixed divide-by-four stage follows, and its output decrements an 8-bit modulus counter. Each time the counter completes a count, it reloads from the modulus register. If the configured level is non-zero, the block also latches a pending request. The request leaves the block with its 3-bit priority level and 8-bit vector number.

Two registers are reached through a small write port and a combinational read port. The timer register holds the prescale select and the modulus. The control register holds the priority level and the vector. An acknowledge input clears the pending request. The block compares the level with the processor's current interrupt mask and flags whether the request would be taken. A second flag reports whether the request would be served ahead of an external request, which it does when its level is equal to or higher than the external request's level.

Top module: `periodic_irq_timer`

## Requirements
- R1: After reset the timer register reads 0 and the control register reads 0x00F (level 0, vector 0x0F). `irq_req` is 0.
- R2: A completed count takes `4 * PS * REF_DIV * M` reference enables, where M is the modulus, PS is 512 when timer bit 8 is set and 1 otherwise, and REF_DIV is 1 or 128. With the enable held high, a modulus written into a stopped timer raises the request on the `1 + 4*PS*REF_DIV*M`-th clock edge after the write edge. Consecutive completions are `4*PS*REF_DIV*M` edges apart.
- R3: A modulus written while the counter is running does not change the count in progress. The counter loads the new value when that count completes.
- R4: A modulus of 0 stops the timer at once: no completion occurs and no request is raised.
- R5: A level of 0 suppresses the request, but the counter keeps counting and reloading, so the completion schedule does not change.
- R6: A request stays pending until an acknowledge is captured, and the output is low in the next cycle. Several completions before the acknowledge leave only one pending request. A completion in the same cycle as the acknowledge keeps the request pending.
- R7: While `irq_req` is high, `irq_level` and `irq_vector` carry the configured level and vector. Otherwise both are 0.
- R8: `irq_recognized` is high only while `irq_req` is high and `irq_level` is greater than `cpu_mask`.
- R9: `serve_timer` is high when the request is recognized and its level is equal to or higher than `ext_level`, so the timer wins ties.
- R10: With `wr_sel`/`rd_sel` = 0 the timer register is selected: bits [7:0] hold the modulus and bit 8 the prescale select. With 1 the control register is selected: bits [7:0] hold the vector and bits [10:8] the level. Unused read bits are 0.
- R11: In a build with REF_DIV = 128, with the prescaler off and a modulus of 1, the first request arrives 513 edges after the write.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Reference clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 timer, 1 control |
| wr_data | input | DATA_W | Write data |
| rd_sel | input | 1 | Read source: 0 timer, 1 control |
| rd_data | output | DATA_W | Read data |
| ack | input | 1 | Clears the pending request |
| cpu_mask | input | LVL_W | Current processor interrupt mask |
| ext_level | input | LVL_W | Level of a competing external request (0 = none) |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | LVL_W | Priority level of the request |
| irq_vector | output | VEC_W | Vector number of the request |
| irq_recognized | output | 1 | Request level exceeds the mask |
| serve_timer | output | 1 | Timer request is served before the external one |

## Verification
The hardest case to reach is a completion in the same cycle that an acknowledge is captured. The bench measures the completion schedule of a running modulus-2 count exactly, then times the acknowledge pulse to land on the next completion edge. A deferred modulus change is shown by writing a new value right after a completion and checking that the next interval still uses the old value and the one after uses the new one. The counter's activity while the level is 0 is made visible by enabling the level between two hidden completions and checking that the next request arrives on the original schedule.

// File: rtl/pit_pkg.sv
package pit_pkg;
   typedef enum logic {
      SEL_TIMER = 1'b0,
      SEL_CTRL  = 1'b1
   } pit_reg_sel_e;

   localparam logic [7:0] PIT_VEC_RESET = 8'h0F;

   function automatic int pit_cnt_w(input int div);
      return (div < 2) ? 1 : $clog2(div);
   endfunction
endpackage

// File: rtl/pit_div.sv
module pit_div #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   output logic pulse
);
   localparam int W = pit_pkg::pit_cnt_w(DIV);

   generate
      if (DIV < 1) begin : g_bad
         $error("pit_div: DIV must be at least 1");
      end
      if (DIV == 1) begin : g_pass
         logic unused_pass;
         assign unused_pass = clk ^ rst_n;
         assign pulse = en & ~clr;
      end else begin : g_count
         logic [W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cnt_q <= '0;
            else if (clr)    cnt_q <= '0;
            else if (en)     cnt_q <= (cnt_q == W'(DIV - 1)) ? '0 : cnt_q + 1'b1;
         end
         assign pulse = en & ~clr & (cnt_q == W'(DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
   parameter int MOD_W   = 8,
   parameter int REF_DIV = 1,
   parameter int PS_DIV  = 512,
   parameter int FIX_DIV = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             ps_sel,
   input  logic [MOD_W-1:0] modulus,
   output logic             expire
);
   logic [MOD_W-1:0] cnt_q;
   logic stopped, clr_chain;
   logic ref_p, ps_p, sel_p, dec_p;

   assign stopped   = (modulus == '0);
   assign clr_chain = stopped | (cnt_q == '0);

   pit_div #(.DIV(REF_DIV)) u_ref (.clk(clk), .rst_n(rst_n), .clr(clr_chain), .en(tick),  .pulse(ref_p));
   pit_div #(.DIV(PS_DIV))  u_ps  (.clk(clk), .rst_n(rst_n), .clr(clr_chain), .en(ref_p), .pulse(ps_p));
   assign sel_p = ps_sel ? ps_p : ref_p;
   pit_div #(.DIV(FIX_DIV)) u_fix (.clk(clk), .rst_n(rst_n), .clr(clr_chain), .en(sel_p), .pulse(dec_p));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (stopped)          cnt_q <= '0;
      else if (cnt_q == '0)      cnt_q <= modulus;
      else if (dec_p)            cnt_q <= (cnt_q == MOD_W'(1)) ? modulus : cnt_q - 1'b1;
   end

   assign expire = dec_p & (cnt_q == MOD_W'(1));
endmodule

// File: rtl/pit_req.sv
module pit_req #(
   parameter int LVL_W = 3,
   parameter int VEC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             expire,
   input  logic             ack,
   input  logic [LVL_W-1:0] level,
   input  logic [VEC_W-1:0] vector,
   input  logic [LVL_W-1:0] cpu_mask,
   input  logic [LVL_W-1:0] ext_level,
   output logic             pend_q,
   output logic             irq_req,
   output logic [LVL_W-1:0] irq_level,
   output logic [VEC_W-1:0] irq_vector,
   output logic             irq_recognized,
   output logic             serve_timer
);
   logic enabled;
   assign enabled = (level != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   pend_q <= 1'b0;
      else if (expire && enabled)   pend_q <= 1'b1;
      else if (ack)                 pend_q <= 1'b0;
   end

   assign irq_req        = pend_q & enabled;
   assign irq_level      = irq_req ? level  : '0;
   assign irq_vector     = irq_req ? vector : '0;
   assign irq_recognized = irq_req & (level > cpu_mask);
   assign serve_timer    = irq_recognized & (level >= ext_level);
endmodule

// File: rtl/periodic_irq_timer.sv
module periodic_irq_timer #(
   parameter int MOD_W   = 8,
   parameter int LVL_W   = 3,
   parameter int VEC_W   = 8,
   parameter int DATA_W  = 16,
   parameter int REF_DIV = 1,
   parameter int PS_DIV  = 512,
   parameter int FIX_DIV = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_sel,
   output logic [DATA_W-1:0] rd_data,
   input  logic              ack,
   input  logic [LVL_W-1:0]  cpu_mask,
   input  logic [LVL_W-1:0]  ext_level,
   output logic              irq_req,
   output logic [LVL_W-1:0]  irq_level,
   output logic [VEC_W-1:0]  irq_vector,
   output logic              irq_recognized,
   output logic              serve_timer
);
   import pit_pkg::*;

   localparam int TMR_W  = MOD_W + 1;
   localparam int CTRL_W = VEC_W + LVL_W;

   generate
      if (DATA_W < TMR_W || DATA_W < CTRL_W) begin : g_bad_data
         $error("periodic_irq_timer: DATA_W too narrow for the register fields");
      end
      if (VEC_W < 4) begin : g_bad_vec
         $error("periodic_irq_timer: VEC_W must hold the reset vector");
      end
      if (REF_DIV != 1 && REF_DIV != 128) begin : g_bad_ref
         $error("periodic_irq_timer: REF_DIV must be 1 or 128");
      end
   endgenerate

   logic [MOD_W-1:0] mod_q;
   logic             ps_q;
   logic [LVL_W-1:0] lvl_q;
   logic [VEC_W-1:0] vec_q;
   logic             expire, pend_q;
   logic             unused_wr;

   assign unused_wr = ^wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mod_q <= '0;
         ps_q  <= 1'b0;
         lvl_q <= '0;
         vec_q <= VEC_W'(PIT_VEC_RESET);
      end else if (wr_en) begin
         if (wr_sel == SEL_CTRL) begin
            lvl_q <= wr_data[VEC_W +: LVL_W];
            vec_q <= wr_data[VEC_W-1:0];
         end else begin
            ps_q  <= wr_data[MOD_W];
            mod_q <= wr_data[MOD_W-1:0];
         end
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_sel == SEL_CTRL) rd_data[CTRL_W-1:0] = {lvl_q, vec_q};
      else                    rd_data[TMR_W-1:0]  = {ps_q, mod_q};
   end

   pit_counter #(
      .MOD_W(MOD_W), .REF_DIV(REF_DIV), .PS_DIV(PS_DIV), .FIX_DIV(FIX_DIV)
   ) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .ps_sel(ps_q),
      .modulus(mod_q), .expire(expire)
   );

   pit_req #(.LVL_W(LVL_W), .VEC_W(VEC_W)) u_req (
      .clk(clk), .rst_n(rst_n), .expire(expire), .ack(ack),
      .level(lvl_q), .vector(vec_q), .cpu_mask(cpu_mask), .ext_level(ext_level),
      .pend_q(pend_q), .irq_req(irq_req), .irq_level(irq_level),
      .irq_vector(irq_vector), .irq_recognized(irq_recognized),
      .serve_timer(serve_timer)
   );
endmodule

// File: rtl/pit_checker.sv
module pit_checker #(
   parameter int MOD_W = 8,
   parameter int LVL_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ack,
   input logic             expire,
   input logic             pend_q,
   input logic [MOD_W-1:0] mod_q,
   input logic [LVL_W-1:0] lvl_q,
   input logic [LVL_W-1:0] cpu_mask,
   input logic [LVL_W-1:0] ext_level,
   input logic             irq_req,
   input logic [LVL_W-1:0] irq_level,
   input logic             irq_recognized,
   input logic             serve_timer
);
   // R4: a zero modulus never lets the counter complete
   a_r4_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_q == '0) |-> !expire);
   // R5: level zero keeps the request output low
   a_r5_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_q == '0) |-> !irq_req);
   // R6: pending holds without an acknowledge
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !ack) |=> pend_q);
   // R6: acknowledge without a completion clears the request
   a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !expire) |=> !pend_q);
   // R8: recognition requires a level above the mask
   a_r8_recog: assert property (@(posedge clk) disable iff (!rst_n)
      irq_recognized |-> (irq_req && (irq_level > cpu_mask)));
   // R9: the timer is served only when recognized and not outranked
   a_r9_tie: assert property (@(posedge clk) disable iff (!rst_n)
      serve_timer |-> (irq_recognized && (irq_level >= ext_level)));
endmodule

bind periodic_irq_timer pit_checker #(.MOD_W(MOD_W), .LVL_W(LVL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ack(ack), .expire(expire), .pend_q(pend_q),
   .mod_q(mod_q), .lvl_q(lvl_q), .cpu_mask(cpu_mask), .ext_level(ext_level),
   .irq_req(irq_req), .irq_level(irq_level), .irq_recognized(irq_recognized),
   .serve_timer(serve_timer)
);

// File: tb/periodic_irq_timer_test.sv
module periodic_irq_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b1;
   logic        wr_en = 1'b0;
   logic        wr_sel = 1'b0;
   logic [15:0] wr_data = '0;
   logic        rd_sel = 1'b0;
   logic [15:0] rd_data, f_rd_data;
   logic        ack = 1'b0;
   logic [2:0]  cpu_mask = '0;
   logic [2:0]  ext_level = '0;
   logic        irq_req, f_req;
   logic [2:0]  irq_level, f_level;
   logic [7:0]  irq_vector, f_vector;
   logic        irq_recognized, f_recog, serve_timer, f_serve;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   periodic_irq_timer #(.REF_DIV(1)) uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .ack(ack),
      .cpu_mask(cpu_mask), .ext_level(ext_level), .irq_req(irq_req),
      .irq_level(irq_level), .irq_vector(irq_vector),
      .irq_recognized(irq_recognized), .serve_timer(serve_timer)
   );

   periodic_irq_timer #(.REF_DIV(128)) uut_fast (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(f_rd_data), .ack(ack),
      .cpu_mask(cpu_mask), .ext_level(ext_level), .irq_req(f_req),
      .irq_level(f_level), .irq_vector(f_vector),
      .irq_recognized(f_recog), .serve_timer(f_serve)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input bit sel, input logic [15:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_ack;
      @(negedge clk); ack = 1'b1;
      @(negedge clk); ack = 1'b0;
   endtask

   task automatic wait_rise(input bit fast, input int limit, output int n);
      n = 0;
      while (n < limit) begin
         @(posedge clk); n++;
         @(negedge clk);
         if (fast ? f_req : irq_req) break;
      end
   endtask

   task automatic rd(input bit sel, output logic [15:0] v);
      rd_sel = sel; #1; v = rd_data;
   endtask

   task automatic t_reset;
      logic [15:0] v;
      rd(1'b0, v); chk(v == 16'h0000, "R1 timer reg", v, 0);
      rd(1'b1, v); chk(v == 16'h000F, "R1 ctrl reg", v, 15);
      chk(irq_req == 1'b0, "R1 req", irq_req, 0);
      chk(f_req == 1'b0, "R1 fast req", f_req, 0);
   endtask

   task automatic t_fast;
      int n;
      wr(1'b1, 16'h0140);
      wr(1'b0, 16'h0001);
      wait_rise(1'b1, 2000, n);
      chk(n == 513, "R11 fast-reference first expiry", n, 513);
      wr(1'b0, 16'h0000);
      do_ack;
   endtask

   task automatic t_period;
      int n;
      logic [15:0] v;
      wr(1'b1, 16'h0255);
      rd(1'b1, v); chk(v == 16'h0255, "R10 ctrl readback", v, 16'h255);
      wr(1'b0, 16'h0003);
      wait_rise(1'b0, 200, n);
      chk(n == 13, "R2 first expiry M=3", n, 13);
      chk(irq_vector == 8'h55, "R7 vector", irq_vector, 8'h55);
      chk(irq_level == 3'd2, "R7 level", irq_level, 2);
      do_ack;
      wait_rise(1'b0, 200, n);
      chk(n == 10, "R2 period M=3", n, 10);
      wr(1'b0, 16'h0000);
      do_ack;
      wr(1'b0, 16'h0101);
      rd(1'b0, v); chk(v == 16'h0101, "R10 timer readback", v, 16'h101);
      wait_rise(1'b0, 5000, n);
      chk(n == 2049, "R2 prescaled expiry", n, 2049);
   endtask

   task automatic t_defer;
      int n;
      logic [15:0] v;
      wr(1'b0, 16'h0000);
      do_ack;
      wr(1'b0, 16'h0003);
      wait_rise(1'b0, 200, n);
      chk(n == 13, "R3 start M=3", n, 13);
      wr(1'b0, 16'h0005);
      rd(1'b0, v); chk(v == 16'h0005, "R3 new modulus readable", v, 5);
      do_ack;
      wait_rise(1'b0, 200, n);
      chk(n == 8, "R3 old count finishes", n, 8);
      do_ack;
      wait_rise(1'b0, 200, n);
      chk(n == 18, "R3 new modulus applied", n, 18);
   endtask

   task automatic t_zero;
      int n;
      wr(1'b0, 16'h0000);
      do_ack;
      wait_rise(1'b0, 200, n);
      chk(n == 200 && !irq_req, "R4 stopped", n, 200);
   endtask

   task automatic t_level;
      int n;
      bit seen = 1'b0;
      wr(1'b1, 16'h0022);
      wr(1'b0, 16'h0002);
      for (int i = 0; i < 20; i++) begin
         @(posedge clk); @(negedge clk);
         if (irq_req) seen = 1'b1;
      end
      chk(!seen, "R5 level 0 masks", seen, 0);
      wr(1'b1, 16'h0322);
      wait_rise(1'b0, 200, n);
      chk(n == 3, "R5 counter kept running", n, 3);
   endtask

   task automatic t_hold;
      int n;
      repeat (20) @(negedge clk);
      chk(irq_req == 1'b1, "R6 held across expiries", irq_req, 1);
      do_ack;
      chk(irq_req == 1'b0, "R6 single ack clears", irq_req, 0);
      chk(irq_vector == 8'h00 && irq_level == 3'd0, "R7 zero when idle", irq_vector, 0);
      wait_rise(1'b0, 200, n);
      chk(n == 2, "R6 next expiry", n, 2);
      repeat (7) @(negedge clk);
      ack = 1'b1;
      @(negedge clk); ack = 1'b0;
      chk(irq_req == 1'b1, "R6 expiry beats ack", irq_req, 1);
   endtask

   task automatic t_recog;
      cpu_mask = 3'd2; ext_level = 3'd0; #1;
      chk(irq_recognized == 1'b1, "R8 above mask", irq_recognized, 1);
      cpu_mask = 3'd3; #1;
      chk(irq_recognized == 1'b0, "R8 equal mask", irq_recognized, 0);
      cpu_mask = 3'd7; #1;
      chk(irq_recognized == 1'b0, "R8 mask 7", irq_recognized, 0);
      cpu_mask = 3'd2; ext_level = 3'd3; #1;
      chk(serve_timer == 1'b1, "R9 tie wins", serve_timer, 1);
      ext_level = 3'd4; #1;
      chk(serve_timer == 1'b0, "R9 higher external", serve_timer, 0);
      ext_level = 3'd2; #1;
      chk(serve_timer == 1'b1, "R9 lower external", serve_timer, 1);
      cpu_mask = 3'd0; ext_level = 3'd0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_fast;
      t_period;
      t_defer;
      t_zero;
      t_level;
      t_hold;
      t_recog;
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule